// File: doc/BRIEF.md
# Multi-Hart Machine Timer Comparator

This block is a memory-mapped machine timer for a cluster of harts. It keeps one free-running 64-bit time counter shared by every hart and, for each hart, a 64-bit compare register. Each hart has a level-sensitive timer interrupt line. The line is high whenever that hart's compare value is at or below the current time. This includes the cycle right after software writes a compare value that already lies in the past.

Software reaches the registers over a simple single-cycle register bus. Each request is accepted in the cycle it is presented, and a response follows one clock later. Each register can be accessed as one 64-bit word or as separate 32-bit low and high halves. A half-width write merges into the existing value. An access that names a hart outside the configured range, or an unsupported byte offset, is flagged as an error, reads as zero and changes nothing.

The bus controller has two named states. In ST_IDLE no response is pending. In ST_RESP a response is presented. From either state, a request moves the controller to ST_RESP and the absence of a request moves it to ST_IDLE.

Top module: `hart_timer_cmp`

## Requirements
- R1: After reset every compare register reads all ones, the time counter reads zero, every irq bit is 0 and rsp_valid is 0.
- R2: The compare register of hart h (HART_BASE <= h < HART_BASE+NUM_HARTS) occupies the 8-byte slot at byte address 8*h. The time counter occupies the 8-byte slot at byte address TIME_OFS. Within a slot, offset 0 is the low half and offset 4 is the high half.
- R3: A read with req_full=1 at offset 0 returns all 64 bits. A read with req_full=0 at offset 0 returns bits 31:0 in rsp_rdata[31:0]. A read at offset 4 returns bits 63:32 in rsp_rdata[31:0]. In the two half-width cases rsp_rdata[63:32] is zero.
- R4: A write with req_full=1 at offset 0 replaces all 64 bits. A write with req_full=0 at offset 0 replaces bits 31:0 and keeps bits 63:32. A write at offset 4 replaces bits 63:32 with req_wdata[31:0] and keeps bits 31:0.
- R5: irq[i] (for hart HART_BASE+i) is 1 when compare <= time as an unsigned 64-bit comparison. It updates exactly one clock edge after the compare value or the time changes, including a write of a value already in the past and the all-ones boundary.
- R6: irq[i] is 0 while compare > time, and it rises one edge after the counter reaches the compare value.
- R7: The time counter increments by one on each clock edge with tick=1. A bus write to it takes priority over the increment in the same cycle. It supports the same split access rules as R3 and R4.
- R8: After a write to the time counter, every hart's irq is re-evaluated against its unchanged compare value.
- R9: An access to a compare slot whose hart is below HART_BASE or at or above HART_BASE+NUM_HARTS gives rsp_err=1 and rsp_rdata=0, and it changes no compare register.
- R10: An access whose byte offset within the slot is neither 0 nor 4 gives rsp_err=1 and rsp_rdata=0, and it changes no register.
- R11: rsp_valid is 1 in the cycle after each accepted request and 0 otherwise. A write response carries rsp_rdata=0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase enable pulse, one count per high cycle |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_full | input | 1 | 1 = 64-bit access, 0 = 32-bit access |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Write data (half writes use bits 31:0) |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Request was rejected as invalid |
| rsp_rdata | output | 64 | Read data |
| irq | output | NUM_HARTS | Per-hart timer interrupt, bit i = hart HART_BASE+i |

## Verification
A corrupted compare register shows at the ports in two ways. Its readback is wrong on the very next response. Its irq bit is also wrong one edge after the counter crosses the value it should hold, so merge errors are checked by both reading back and driving the counter past the compare point. A wrong time value shows as a wrong read one cycle later, and as an irq that is off by a tick at the threshold. Rejected accesses are followed by a readback of the slots they could have hit, so a decode leak appears in the next response.

// File: rtl/htc_pkg.sv
package htc_pkg;

    typedef enum logic [1:0] {
        TGT_CMP  = 2'd0,
        TGT_TIME = 2'd1,
        TGT_NONE = 2'd2
    } tgt_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } bus_st_e;

    // Merge write data into an existing 64-bit register.
    function automatic logic [63:0] merge64(input logic [63:0] old_v,
                                            input logic [63:0] wd,
                                            input logic        full,
                                            input logic        hi);
        if (hi)
            return {wd[31:0], old_v[31:0]};
        else if (full)
            return wd;
        else
            return {old_v[63:32], wd[31:0]};
    endfunction

    // Read view of a 64-bit register for a given access shape.
    function automatic logic [63:0] view64(input logic [63:0] v,
                                           input logic        full,
                                           input logic        hi);
        if (hi)
            return {32'h0, v[63:32]};
        else if (full)
            return v;
        else
            return {32'h0, v[31:0]};
    endfunction

endpackage

// File: rtl/htc_decode.sv
module htc_decode
    import htc_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int NUM_HARTS = 4,
    parameter int HART_BASE = 1,
    parameter int TIME_OFS  = 16'h4000,
    parameter int IDX_W     = 2
) (
    input  logic [ADDR_W-1:0] addr,
    output tgt_e              tgt,
    output logic              hi,
    output logic [IDX_W-1:0]  idx
);
    localparam int SLOT_W = ADDR_W - 3;
    localparam logic [SLOT_W-1:0] FIRST_SLOT = SLOT_W'(HART_BASE);
    localparam logic [SLOT_W-1:0] END_SLOT   = SLOT_W'(HART_BASE + NUM_HARTS);
    localparam logic [SLOT_W-1:0] TIME_SLOT  = SLOT_W'(TIME_OFS / 8);

    logic [SLOT_W-1:0] slot;
    logic              off_ok;

    always_comb begin
        slot   = addr[ADDR_W-1:3];
        off_ok = (addr[1:0] == 2'b00);
        hi     = addr[2];
        idx    = IDX_W'(slot - FIRST_SLOT);
        tgt    = TGT_NONE;
        if (off_ok) begin
            if (slot == TIME_SLOT)
                tgt = TGT_TIME;
            else if (slot >= FIRST_SLOT && slot < END_SLOT)
                tgt = TGT_CMP;
        end
    end
endmodule

// File: rtl/htc_cmp_bank.sv
module htc_cmp_bank
    import htc_pkg::*;
#(
    parameter int NUM_HARTS = 4,
    parameter int IDX_W     = 2
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       wr_en,
    input  logic [IDX_W-1:0]           wr_idx,
    input  logic                       wr_hi,
    input  logic                       wr_full,
    input  logic [63:0]                wr_data,
    input  logic [63:0]                time_now,
    output logic [NUM_HARTS-1:0][63:0] cmp_q,
    output logic [NUM_HARTS-1:0]       irq_q
);
    logic [63:0] cmp_r [NUM_HARTS];
    logic        irq_r [NUM_HARTS];

    for (genvar gi = 0; gi < NUM_HARTS; gi++) begin : g_hart
        always_ff @(posedge clk) begin
            if (rst) begin
                cmp_r[gi] <= '1;
                irq_r[gi] <= 1'b0;
            end else begin
                if (wr_en && wr_idx == IDX_W'(gi))
                    cmp_r[gi] <= merge64(cmp_r[gi], wr_data, wr_full, wr_hi);
                irq_r[gi] <= (cmp_r[gi] <= time_now);
            end
        end
        assign cmp_q[gi] = cmp_r[gi];
        assign irq_q[gi] = irq_r[gi];
    end
endmodule

// File: rtl/htc_timebase.sv
module htc_timebase
    import htc_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        tick,
    input  logic        wr_en,
    input  logic        wr_hi,
    input  logic        wr_full,
    input  logic [63:0] wr_data,
    output logic [63:0] time_q
);
    always_ff @(posedge clk) begin
        if (rst)
            time_q <= '0;
        else if (wr_en)
            time_q <= merge64(time_q, wr_data, wr_full, wr_hi);
        else if (tick)
            time_q <= time_q + 64'd1;
    end
endmodule

// File: rtl/hart_timer_cmp.sv
module hart_timer_cmp
    import htc_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int NUM_HARTS = 4,
    parameter int HART_BASE = 1,
    parameter int TIME_OFS  = 16'h4000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 tick,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic                 req_full,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [63:0]          req_wdata,
    output logic                 rsp_valid,
    output logic                 rsp_err,
    output logic [63:0]          rsp_rdata,
    output logic [NUM_HARTS-1:0] irq
);
    localparam int IDX_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

    tgt_e                       tgt;
    logic                       acc_hi;
    logic [IDX_W-1:0]           acc_idx;
    logic                       acc_bad;
    logic                       cmp_wr;
    logic                       time_wr;
    logic [NUM_HARTS-1:0][63:0] cmp_q;
    logic [63:0]                time_q;
    logic [63:0]                rd_view;
    logic [63:0]                rdata_q;
    logic                       err_q;
    bus_st_e                    state_q, state_nx;

    htc_decode #(
        .ADDR_W(ADDR_W), .NUM_HARTS(NUM_HARTS), .HART_BASE(HART_BASE),
        .TIME_OFS(TIME_OFS), .IDX_W(IDX_W)
    ) u_decode (
        .addr(req_addr), .tgt(tgt), .hi(acc_hi), .idx(acc_idx)
    );

    assign acc_bad = (tgt == TGT_NONE);
    assign cmp_wr  = req_valid && req_write && (tgt == TGT_CMP);
    assign time_wr = req_valid && req_write && (tgt == TGT_TIME);

    htc_cmp_bank #(.NUM_HARTS(NUM_HARTS), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst(rst), .wr_en(cmp_wr), .wr_idx(acc_idx),
        .wr_hi(acc_hi), .wr_full(req_full), .wr_data(req_wdata),
        .time_now(time_q), .cmp_q(cmp_q), .irq_q(irq)
    );

    htc_timebase u_time (
        .clk(clk), .rst(rst), .tick(tick), .wr_en(time_wr),
        .wr_hi(acc_hi), .wr_full(req_full), .wr_data(req_wdata),
        .time_q(time_q)
    );

    // Read data selection for the current request.
    always_comb begin
        unique case (tgt)
            TGT_CMP:  rd_view = view64(cmp_q[acc_idx], req_full, acc_hi);
            TGT_TIME: rd_view = view64(time_q, req_full, acc_hi);
            default:  rd_view = '0;
        endcase
    end

    // Bus response state register.
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_nx;
    end

    always_comb begin
        unique case (state_q)
            ST_IDLE: state_nx = req_valid ? ST_RESP : ST_IDLE;
            ST_RESP: state_nx = req_valid ? ST_RESP : ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Response payload registers, loaded on the accepting edge.
    always_ff @(posedge clk) begin
        if (rst) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else if (req_valid) begin
            rdata_q <= (!req_write) ? rd_view : 64'h0;
            err_q   <= acc_bad;
        end else begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end
    end

    // Outputs driven by the response state.
    always_comb begin
        rsp_valid = (state_q == ST_RESP);
        rsp_err   = (state_q == ST_RESP) && err_q;
        rsp_rdata = (state_q == ST_RESP) ? rdata_q : 64'h0;
    end
endmodule

// File: rtl/htc_checker.sv
module htc_checker #(
    parameter int NUM_HARTS = 4
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      tick,
    input logic                      req_valid,
    input logic                      acc_bad,
    input logic                      time_wr,
    input logic [63:0]               time_q,
    input logic [NUM_HARTS*64-1:0]   cmp_flat,
    input logic [NUM_HARTS-1:0]      irq,
    input logic                      rsp_valid,
    input logic                      rsp_err,
    input logic [63:0]               rsp_rdata
);
    assert_rsp_after_req_R11: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_no_rsp_idle_R11: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    // R9 and R10: a rejected access changes no compare value and reads zero.
    assert_bad_access_inert_R9: assert property (@(posedge clk) disable iff (rst)
        (req_valid && acc_bad) |=> ($stable(cmp_flat) && rsp_err && rsp_rdata == 64'h0));

    assert_time_counts_R7: assert property (@(posedge clk) disable iff (rst)
        (tick && !time_wr) |=> (time_q == $past(time_q) + 64'd1));

    assert_time_holds_R7: assert property (@(posedge clk) disable iff (rst)
        (!tick && !time_wr) |=> $stable(time_q));

    for (genvar gi = 0; gi < NUM_HARTS; gi++) begin : g_irq
        assert_irq_tracks_R5: assert property (@(posedge clk) disable iff (rst)
            1'b1 |=> (irq[gi] == ($past(cmp_flat[gi*64 +: 64]) <= $past(time_q))));
    end
endmodule

bind hart_timer_cmp htc_checker #(.NUM_HARTS(NUM_HARTS)) u_htc_checker (
    .clk(clk), .rst(rst), .tick(tick), .req_valid(req_valid),
    .acc_bad(acc_bad), .time_wr(time_wr), .time_q(time_q),
    .cmp_flat(cmp_q), .irq(irq), .rsp_valid(rsp_valid),
    .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
);

// File: tb/hart_timer_cmp_test.sv
`timescale 1ns/1ps
module hart_timer_cmp_test;
    localparam int NH = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic        req_full = 1'b0;
    logic [15:0] req_addr = '0;
    logic [63:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_err;
    logic [63:0] rsp_rdata;
    logic [NH-1:0] irq;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    hart_timer_cmp #(.ADDR_W(16), .NUM_HARTS(NH), .HART_BASE(1), .TIME_OFS(16'h4000)) uut (
        .clk(clk), .rst(rst), .tick(tick), .req_valid(req_valid),
        .req_write(req_write), .req_full(req_full), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .irq(irq)
    );

    typedef struct packed {
        logic        wr;
        logic        full;
        logic [15:0] addr;
        logic [63:0] wd;
        logic [63:0] exp;
        logic        err;
    } vec_t;

    // Harts 1..4 sit at 0x08,0x10,0x18,0x20; time at 0x4000.
    localparam vec_t VECS [15] = '{
        '{1'b0, 1'b1, 16'h0008, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0},          // R1 R3
        '{1'b1, 1'b1, 16'h0008, 64'h1122_3344_5566_7788, 64'h0, 1'b0},          // R4 R11
        '{1'b0, 1'b0, 16'h0008, 64'h0, 64'h0000_0000_5566_7788, 1'b0},          // R3
        '{1'b0, 1'b0, 16'h000C, 64'h0, 64'h0000_0000_1122_3344, 1'b0},          // R3
        '{1'b1, 1'b0, 16'h0008, 64'h9999_9999_AAAA_BBBB, 64'h0, 1'b0},          // R4
        '{1'b0, 1'b1, 16'h0008, 64'h0, 64'h1122_3344_AAAA_BBBB, 1'b0},          // R4
        '{1'b1, 1'b0, 16'h000C, 64'h0000_0000_CCCC_DDDD, 64'h0, 1'b0},          // R4
        '{1'b0, 1'b1, 16'h0008, 64'h0, 64'hCCCC_DDDD_AAAA_BBBB, 1'b0},          // R4
        '{1'b0, 1'b1, 16'h0000, 64'h0, 64'h0, 1'b1},                            // R9
        '{1'b1, 1'b1, 16'h0028, 64'h0, 64'h0, 1'b1},                            // R9
        '{1'b0, 1'b1, 16'h0028, 64'h0, 64'h0, 1'b1},                            // R9
        '{1'b0, 1'b1, 16'h0018, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0},          // R2
        '{1'b0, 1'b0, 16'h000A, 64'h0, 64'h0, 1'b1},                            // R10
        '{1'b1, 1'b0, 16'h0012, 64'h0, 64'h0, 1'b1},                            // R10
        '{1'b0, 1'b1, 16'h0010, 64'h0, 64'hFFFF_FFFF_FFFF_FFFF, 1'b0}           // R10
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic full, input logic [15:0] a,
                          input logic [63:0] d, output logic [63:0] rd,
                          output logic err, output logic vld);
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_full = full; req_addr = a; req_wdata = d;
        @(negedge clk);
        rd = rsp_rdata; err = rsp_err; vld = rsp_valid;
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1'b1;
        @(negedge clk); tick = 1'b0;
    endtask

    initial begin
        logic [63:0] rd;
        logic        er;
        logic        vl;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 irq at reset", 64'(irq), 64'h0);
        chk("R1 rsp_valid at reset", 64'(rsp_valid), 64'h0);
        access(1'b0, 1'b1, 16'h4000, 64'h0, rd, er, vl);
        chk("R1 time at reset", rd, 64'h0);

        for (int i = 0; i < 15; i++) begin
            access(VECS[i].wr, VECS[i].full, VECS[i].addr, VECS[i].wd, rd, er, vl);
            chk($sformatf("vector %0d rdata", i), rd, VECS[i].exp);
            chk($sformatf("vector %0d err", i), 64'(er), 64'(VECS[i].err));
            chk($sformatf("vector %0d valid R11", i), 64'(vl), 64'h1);
        end

        // R5: past compare value, one-edge latency
        access(1'b1, 1'b1, 16'h0010, 64'h0, rd, er, vl);
        chk("R5 irq not yet", 64'(irq[1]), 64'h0);
        @(negedge clk);
        chk("R5 irq on past compare", 64'(irq[1]), 64'h1);

        // R6: future compare, counter reaches it
        access(1'b1, 1'b1, 16'h4000, 64'd100, rd, er, vl);
        access(1'b1, 1'b1, 16'h0018, 64'd103, rd, er, vl);
        @(negedge clk);
        chk("R6 irq low for future", 64'(irq[2]), 64'h0);
        pulse_tick();
        pulse_tick();
        @(negedge clk);
        chk("R6 irq low one short", 64'(irq[2]), 64'h0);
        pulse_tick();
        @(negedge clk);
        chk("R6 irq at threshold", 64'(irq[2]), 64'h1);
        access(1'b0, 1'b1, 16'h4000, 64'h0, rd, er, vl);
        chk("R7 time after ticks", rd, 64'd103);

        // R8: time writes re-evaluate every hart
        access(1'b1, 1'b1, 16'h4000, 64'd0, rd, er, vl);
        @(negedge clk);
        chk("R8 irq after time=0", 64'(irq), 64'b0010);
        access(1'b1, 1'b1, 16'h4000, 64'd200, rd, er, vl);
        @(negedge clk);
        chk("R8 irq after time=200", 64'(irq), 64'b0110);

        // R7: split time access and write priority over tick
        access(1'b1, 1'b0, 16'h4004, 64'h1, rd, er, vl);
        access(1'b0, 1'b1, 16'h4000, 64'h0, rd, er, vl);
        chk("R7 time high half write", rd, 64'h0000_0001_0000_00C8);
        access(1'b0, 1'b0, 16'h4004, 64'h0, rd, er, vl);
        chk("R7 time high half read", rd, 64'h1);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_full = 1'b0;
        req_addr = 16'h4000; req_wdata = 64'h5; tick = 1'b1;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0; tick = 1'b0;
        access(1'b0, 1'b1, 16'h4000, 64'h0, rd, er, vl);
        chk("R7 write beats tick", rd, 64'h0000_0001_0000_0005);

        // R5 boundary: all-ones time equals all-ones compare
        access(1'b1, 1'b1, 16'h4000, 64'hFFFF_FFFF_FFFF_FFFF, rd, er, vl);
        @(negedge clk);
        chk("R5 all-ones boundary", 64'(irq), 64'b1111);

        // R11: no response without request
        @(negedge clk);
        chk("R11 idle no response", 64'(rsp_valid), 64'h0);

        if (!finished) begin
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule